// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller with Selectable Write Policies

This block sits between a processor's load/store port and a slower main memory. It holds a small direct-mapped set of multi-word lines. Each line has a tag, a valid bit, a dirty bit and its data, all kept in registers inside the block. A load whose address finds a matching valid line is answered in the same cycle it is presented. The tag and the data word are looked up in parallel, and the word is released only when the tag compare succeeds. A load that misses pulls the whole line from memory in one handshake, installs it, and then answers from the cache.

Two compile-time parameters choose the store behaviour. WRITE_BACK selects between write-through, where every store is also sent to memory, and write-back, where a store only marks the line dirty and the line is copied out when it is evicted. WRITE_ALLOC selects what a store miss does. With allocation, the target line is fetched, the stored word is merged into it, and it is installed under its new tag. Without allocation, the word goes straight to memory and the cache is left alone. A store never writes the data array before the tag has been confirmed, so no line ever holds words from two different tags.

The processor holds its request, write flag, address and data stable until it sees cpu_ready high at a clock edge. cpu_ready is a single-cycle completion strobe, and cpu_rdata is valid in that cycle for loads. The memory side raises mem_req and holds it, with a stable line address, until mem_ack is seen. One handshake moves one full line.

Top module: `cc_policy_cache`

## Requirements
- R1: After a synchronous active-low reset, every line is invalid and clean, cpu_ready and mem_req are low, and the first access to any address misses.
- R2: A load that hits raises cpu_ready in the first cycle it is presented, returns the stored word on cpu_rdata, and causes no memory handshake.
- R3: A load that misses (after any eviction) performs exactly one line read with mem_we low, at line address cpu_addr[AW-1:OFS_W], installs the line, and then returns the requested word.
- R4: A store that hits completes no sooner than the second cycle. The data array is written only in a cycle in which the tag lookup reports a hit. In write-back mode the store completes in exactly two cycles.
- R5: With WRITE_ALLOC=1, a store miss fetches the target line, merges the stored word, and installs the line under the new tag. Every other word of that line then reads back its memory value, and a load to the line hits.
- R6: With WRITE_ALLOC=0, a store miss sends the word to memory with no line fetch and leaves tags, valid bits and data unchanged. A later load of that address therefore misses and returns the new value.
- R7: With WRITE_BACK=0, every store, hit or miss, produces one memory word write holding the stored value, and no line ever becomes dirty.
- R8: With WRITE_BACK=1, a store into a resident line updates only the cache, marks the line dirty, and leaves memory unchanged.
- R9: With WRITE_BACK=1, a dirty line chosen for replacement is written to memory with a full mask at its own line address before the new line is read.
- R10: With WRITE_BACK=1, a clean or invalid line chosen for replacement is overwritten with no memory write.
- R11: While a memory handshake is pending (mem_req high, mem_ack low), cpu_ready stays low and mem_req, mem_we and mem_addr hold their values into the next cycle.
- R12: On the memory bus, mem_we=1 means write. Word i of a line sits at bits [i*DW +: DW], and mem_wmask bit i enables word i. A line copy-out uses an all-ones mask, and a single-word write uses a one-hot mask at the word offset cpu_addr[OFS_W-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Word address: tag, index, word offset from high to low |
| cpu_wdata | input | DW | Store data |
| cpu_rdata | output | DW | Load data, valid when cpu_ready is high |
| cpu_ready | output | 1 | One-cycle completion strobe |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = memory write, 0 = line read |
| mem_addr | output | AW-OFS_W | Line address |
| mem_wdata | output | WORDS*DW | Write line (word i at bits i*DW) |
| mem_wmask | output | WORDS | Per-word write enable |
| mem_rdata | input | WORDS*DW | Read line, valid with mem_ack |
| mem_ack | input | 1 | Memory completion strobe |

## Verification
On every cycle, the assertions check the sequencing rules. The data array takes a word only under a confirmed hit, and a line is installed only on a read acknowledge. A line is evicted only when it is valid and dirty, dirty bits never appear in write-through builds, and no line is installed by a store when allocation is off. The memory request stays stable until acknowledged, and completion is withheld during it. Only the bench's scenarios can show the end-to-end effects. These are that loads always return the latest stored value across conflict evictions, and that each access makes exactly the expected number of line reads and writes for its policy. They also cover that memory holds or lacks a stored word as each policy dictates, and that hits complete in one or two cycles. The bench drives all four policy combinations side by side.

// File: rtl/cc_pkg.sv
// Package: shared types for the policy cache controller.
// Assumes nothing beyond IEEE 1800-2017 enums.
package cc_pkg;

    // Sequencer states of the controller.
    typedef enum logic [2:0] {
        ST_IDLE,   // lookup cycle
        ST_WHIT,   // confirmed store hit: write the word
        ST_EVICT,  // copy a dirty victim line out
        ST_FETCH,  // read the target line in
        ST_WTHRU   // send one word to memory
    } cc_state_t;

    // Kind of memory transfer currently requested.
    typedef enum logic [1:0] {
        MO_NONE,
        MO_EVICT,
        MO_FETCH,
        MO_WORD
    } cc_memop_t;

endpackage

// File: rtl/cc_tag_store.sv
// Module: tag, valid and dirty storage with a single lookup port.
// Reports hit for the presented tag at the presented index, and exposes the
// victim line's valid, dirty and tag. Assumes fill and dirty-marking never
// coincide (the sequencer guarantees this).
module cc_tag_store #(
    parameter int LINES      = 16,
    parameter int TAG_W      = 6,
    parameter int WRITE_BACK = 1,
    localparam int IDX_W     = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag_in,
    input  logic             fill_en,
    input  logic             fill_dirty,
    input  logic             mark_dirty,
    output logic             hit,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag
);

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Status bits: cleared by reset, set on fill or on a write-back store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= fill_dirty;
        end else if (mark_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    // Tag array: loaded when a line is installed; no reset needed behind valid.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx] <= tag_in;
        end
    end

    // Lookup port: combinational read of the indexed entry.
    always_comb begin
        line_valid = valid_q[idx];
        line_dirty = dirty_q[idx];
        line_tag   = tag_q[idx];
        hit        = valid_q[idx] && (tag_q[idx] == tag_in);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (valid_q == '0) && (dirty_q == '0)); // R1

    AST_DIRTY_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_q & ~valid_q) == '0); // R8

    generate
        if (WRITE_BACK == 0) begin : g_wt_chk
            AST_WT_NO_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
                dirty_q == '0); // R7
        end
    endgenerate

endmodule

// File: rtl/cc_line_store.sv
// Module: line data storage, one full line per entry.
// Reads the indexed line combinationally; writes either a whole line (fill)
// or the words selected by a mask. Data has no reset: valid bits guard it.
module cc_line_store #(
    parameter int LINES   = 16,
    parameter int WORDS   = 4,
    parameter int DW      = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int LINE_W = WORDS * DW
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              word_we,
    input  logic [WORDS-1:0]  word_mask,
    input  logic [DW-1:0]     word_data,
    output logic [LINE_W-1:0] rd_line
);

    logic [LINE_W-1:0] lines_q [LINES];

    // Data array update: full-line install has priority over a word store.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            lines_q[idx] <= fill_line;
        end else if (word_we) begin
            for (int w = 0; w < WORDS; w++) begin
                if (word_mask[w]) begin
                    lines_q[idx][w*DW +: DW] <= word_data;
                end
            end
        end
    end

    // Speculative read of the indexed line, in parallel with the tag compare.
    assign rd_line = lines_q[idx];

endmodule

// File: rtl/cc_seq_fsm.sv
// Module: access sequencer for the policy cache.
// Decides per lookup whether to answer, write a confirmed hit, evict, fetch
// or forward a word, according to WRITE_BACK and WRITE_ALLOC. Assumes the
// processor holds its request inputs stable until cpu_ready.
module cc_seq_fsm
    import cc_pkg::*;
#(
    parameter int WRITE_BACK  = 1,
    parameter int WRITE_ALLOC = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cpu_req,
    input  logic      cpu_we,
    input  logic      lookup_hit,
    input  logic      victim_valid,
    input  logic      victim_dirty,
    input  logic      mem_ack,
    output logic      cpu_ready,
    output logic      mem_req,
    output logic      mem_we,
    output cc_memop_t mem_op,
    output logic      word_we,
    output logic      line_fill,
    output logic      fill_dirty,
    output logic      mark_dirty
);

    localparam bit WB = (WRITE_BACK != 0);
    localparam bit WA = (WRITE_ALLOC != 0);

    cc_state_t state_q, state_d;

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state and control decode.
    always_comb begin
        state_d    = state_q;
        cpu_ready  = 1'b0;
        word_we    = 1'b0;
        line_fill  = 1'b0;
        fill_dirty = 1'b0;
        mark_dirty = 1'b0;
        mem_op     = MO_NONE;
        case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (lookup_hit) begin
                        if (cpu_we) begin
                            state_d = ST_WHIT;
                        end else begin
                            cpu_ready = 1'b1;
                        end
                    end else if (cpu_we && !WA) begin
                        state_d = ST_WTHRU;
                    end else if (WB && victim_valid && victim_dirty) begin
                        state_d = ST_EVICT;
                    end else begin
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_WHIT: begin
                word_we = 1'b1;
                if (WB) begin
                    mark_dirty = 1'b1;
                    cpu_ready  = 1'b1;
                    state_d    = ST_IDLE;
                end else begin
                    state_d = ST_WTHRU;
                end
            end
            ST_EVICT: begin
                mem_op = MO_EVICT;
                if (mem_ack) begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_op = MO_FETCH;
                if (mem_ack) begin
                    line_fill  = 1'b1;
                    fill_dirty = WB && cpu_we;
                    state_d    = (cpu_we && !WB) ? ST_WTHRU : ST_IDLE;
                end
            end
            ST_WTHRU: begin
                mem_op = MO_WORD;
                if (mem_ack) begin
                    cpu_ready = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Memory strobes derived from the transfer kind.
    assign mem_req = (mem_op != MO_NONE);
    assign mem_we  = (mem_op == MO_EVICT) || (mem_op == MO_WORD);

    AST_EVICT_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVICT) |-> (victim_valid && victim_dirty)); // R9

    AST_EVICT_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_op == MO_EVICT && mem_ack) |=> (mem_op == MO_FETCH)); // R9

endmodule

// File: rtl/cc_policy_cache.sv
// Module: top of the direct-mapped cache controller with selectable write
// policies. Splits the word address into tag, index and offset, selects the
// load word, merges a store into a fetched line and drives the memory bus.
// Assumes WORDS >= 2 and LINES >= 2, both powers of two, and that mem_rdata
// is valid in the cycle mem_ack is high.
module cc_policy_cache
    import cc_pkg::*;
#(
    parameter int LINES       = 16,
    parameter int WORDS       = 4,
    parameter int DW          = 32,
    parameter int AW          = 12,
    parameter int WRITE_BACK  = 1,
    parameter int WRITE_ALLOC = 1,
    localparam int IDX_W      = $clog2(LINES),
    localparam int OFS_W      = $clog2(WORDS),
    localparam int TAG_W      = AW - IDX_W - OFS_W,
    localparam int LINE_W     = WORDS * DW,
    localparam int LA_W       = AW - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [LA_W-1:0]   mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    output logic [WORDS-1:0]  mem_wmask,
    input  logic [LINE_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    logic [OFS_W-1:0]  word_off;
    logic [IDX_W-1:0]  line_idx;
    logic [TAG_W-1:0]  addr_tag;
    logic              lookup_hit;
    logic              victim_valid;
    logic              victim_dirty;
    logic [TAG_W-1:0]  victim_tag;
    logic [LINE_W-1:0] cur_line;
    logic [LINE_W-1:0] merged_line;
    logic [WORDS-1:0]  word_mask;
    logic [DW-1:0]     rd_words [WORDS];
    logic              word_we;
    logic              line_fill;
    logic              fill_dirty;
    logic              mark_dirty;
    cc_memop_t         mem_op;

    // Address split: tag | index | word offset.
    assign word_off = cpu_addr[OFS_W-1:0];
    assign line_idx = cpu_addr[OFS_W +: IDX_W];
    assign addr_tag = cpu_addr[AW-1 -: TAG_W];

    // Per-word slicing, store merge and word mask.
    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            assign word_mask[w] = (word_off == OFS_W'(w));
            assign rd_words[w]  = cur_line[w*DW +: DW];
            assign merged_line[w*DW +: DW] =
                (cpu_we && word_mask[w]) ? cpu_wdata : mem_rdata[w*DW +: DW];
        end
    endgenerate

    // Load word selection from the speculatively read line.
    assign cpu_rdata = rd_words[word_off];

    cc_tag_store #(
        .LINES      (LINES),
        .TAG_W      (TAG_W),
        .WRITE_BACK (WRITE_BACK)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (line_idx),
        .tag_in     (addr_tag),
        .fill_en    (line_fill),
        .fill_dirty (fill_dirty),
        .mark_dirty (mark_dirty),
        .hit        (lookup_hit),
        .line_valid (victim_valid),
        .line_dirty (victim_dirty),
        .line_tag   (victim_tag)
    );

    cc_line_store #(
        .LINES (LINES),
        .WORDS (WORDS),
        .DW    (DW)
    ) u_data (
        .clk       (clk),
        .idx       (line_idx),
        .fill_en   (line_fill),
        .fill_line (merged_line),
        .word_we   (word_we),
        .word_mask (word_mask),
        .word_data (cpu_wdata),
        .rd_line   (cur_line)
    );

    cc_seq_fsm #(
        .WRITE_BACK  (WRITE_BACK),
        .WRITE_ALLOC (WRITE_ALLOC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .lookup_hit   (lookup_hit),
        .victim_valid (victim_valid),
        .victim_dirty (victim_dirty),
        .mem_ack      (mem_ack),
        .cpu_ready    (cpu_ready),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_op       (mem_op),
        .word_we      (word_we),
        .line_fill    (line_fill),
        .fill_dirty   (fill_dirty),
        .mark_dirty   (mark_dirty)
    );

    // Memory bus drive: victim line on eviction, placed word otherwise.
    always_comb begin
        mem_addr  = (mem_op == MO_EVICT) ? {victim_tag, line_idx} : {addr_tag, line_idx};
        mem_wdata = (mem_op == MO_EVICT) ? cur_line : {WORDS{cpu_wdata}};
        case (mem_op)
            MO_EVICT: mem_wmask = '1;
            MO_WORD:  mem_wmask = word_mask;
            default:  mem_wmask = '0;
        endcase
    end

    AST_WORD_WRITE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        word_we |-> lookup_hit); // R4

    AST_FILL_ON_READ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        line_fill |-> (mem_req && mem_ack && !mem_we)); // R3

    AST_NO_READY_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |-> !cpu_ready); // R11

    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11

    AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ((&mem_wmask) || ($countones(mem_wmask) == 1))); // R12

    generate
        if (WRITE_ALLOC == 0) begin : g_na_chk
            AST_NO_STORE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
                !(line_fill && cpu_we)); // R6
        end
    endgenerate

endmodule

// File: tb/cc_policy_cache_tb.sv
// Bench: four controllers, one per policy combination, each with its own
// memory model. A bench-side cache model predicts hits, evictions and the
// memory traffic of each access; a shadow array holds the latest value of
// every word. Directed corner cases run first, then seeded random accesses.
module cc_policy_cache_tb;

    localparam int LINES  = 16;
    localparam int WORDS  = 4;
    localparam int DW     = 32;
    localparam int AW     = 12;
    localparam int OFS_W  = 2;
    localparam int IDX_W  = 4;
    localparam int TAG_W  = AW - IDX_W - OFS_W;
    localparam int LA_W   = AW - OFS_W;
    localparam int LINE_W = WORDS * DW;
    localparam int NP     = 4;
    localparam int NWORD  = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic              cpu_req   [NP];
    logic              cpu_we    [NP];
    logic [AW-1:0]     cpu_addr  [NP];
    logic [DW-1:0]     cpu_wdata [NP];
    logic [DW-1:0]     cpu_rdata [NP];
    logic              cpu_ready [NP];
    logic              mem_req   [NP];
    logic              mem_we    [NP];
    logic [LA_W-1:0]   mem_addr  [NP];
    logic [LINE_W-1:0] mem_wdata [NP];
    logic [WORDS-1:0]  mem_wmask [NP];
    logic [LINE_W-1:0] mem_rdata [NP];
    logic              mem_ack   [NP];

    // p0: write-back+allocate, p1: write-back+no-allocate,
    // p2: write-through+allocate, p3: write-through+no-allocate
    generate
        for (genvar g = 0; g < NP; g++) begin : g_dut
            cc_policy_cache #(
                .LINES (LINES), .WORDS (WORDS), .DW (DW), .AW (AW),
                .WRITE_BACK  ((g < 2) ? 1 : 0),
                .WRITE_ALLOC ((g % 2 == 0) ? 1 : 0)
            ) u_dut (
                .clk (clk), .rst_n (rst_n),
                .cpu_req (cpu_req[g]), .cpu_we (cpu_we[g]), .cpu_addr (cpu_addr[g]),
                .cpu_wdata (cpu_wdata[g]), .cpu_rdata (cpu_rdata[g]), .cpu_ready (cpu_ready[g]),
                .mem_req (mem_req[g]), .mem_we (mem_we[g]), .mem_addr (mem_addr[g]),
                .mem_wdata (mem_wdata[g]), .mem_wmask (mem_wmask[g]),
                .mem_rdata (mem_rdata[g]), .mem_ack (mem_ack[g])
            );
        end
    endgenerate

    logic [DW-1:0]    mem_w [NP][NWORD];
    logic [DW-1:0]    sh_w  [NP][NWORD];
    int               rd_cnt [NP];
    int               wr_cnt [NP];
    int               viol   [NP];
    int               lat_cnt [NP];
    int               lat_tgt [NP];
    bit               mv [NP][LINES];
    bit               md [NP][LINES];
    logic [TAG_W-1:0] mt [NP][LINES];
    int               n_chk = 0;
    int               n_err = 0;
    bit               done = 1'b0;

    function automatic bit is_wb(input int p);
        return p < 2;
    endfunction

    function automatic bit is_al(input int p);
        return (p % 2) == 0;
    endfunction

    function automatic logic [AW-1:0] mk(input int t, input int i, input int o);
        return {TAG_W'(t), IDX_W'(i), OFS_W'(o)};
    endfunction

    function automatic logic [DW-1:0] init_val(input int p, input int a);
        return (32'(a) * 32'h9E37_79B1) ^ (32'(p) << 28) ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model: registered ack after 0..2 extra cycles; word i of a line
    // at bits i*DW, mask bit i enables word i (R12).
    always @(posedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (!rst_n) begin
                mem_ack[p] <= 1'b0;
                lat_cnt[p] = 0;
            end else if (mem_ack[p]) begin
                if (mem_req[p]) begin
                    if (mem_we[p]) begin
                        for (int w = 0; w < WORDS; w++) begin
                            if (mem_wmask[p][w])
                                mem_w[p][{mem_addr[p], OFS_W'(w)}] = mem_wdata[p][w*DW +: DW];
                        end
                        wr_cnt[p]++;
                    end else begin
                        rd_cnt[p]++;
                    end
                end
                mem_ack[p] <= 1'b0;
                lat_cnt[p] = 0;
            end else if (mem_req[p]) begin
                if (lat_cnt[p] >= lat_tgt[p]) begin
                    mem_ack[p] <= 1'b1;
                    for (int w = 0; w < WORDS; w++)
                        mem_rdata[p][w*DW +: DW] <= mem_w[p][{mem_addr[p], OFS_W'(w)}];
                    lat_tgt[p] = int'($urandom % 3);
                end else begin
                    lat_cnt[p]++;
                end
            end
        end
    end

    // Monitor: completion must not appear while a handshake is pending (R11).
    always @(negedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (rst_n && mem_req[p] && !mem_ack[p] && cpu_ready[p]) viol[p]++;
        end
    end

    // One processor access: inputs set after a rising edge, completion
    // sampled at falling edges, request dropped just after the accepting edge.
    task automatic access(input int p, input bit we, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, output int cyc, output logic [DW-1:0] rd);
        @(posedge clk);
        #1;
        cpu_req[p] = 1'b1; cpu_we[p] = we; cpu_addr[p] = a; cpu_wdata[p] = d;
        cyc = 0;
        rd = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cpu_ready[p]) begin
                rd = cpu_rdata[p];
                break;
            end
            if (cyc > 2000) break;
        end
        @(posedge clk);
        #1;
        cpu_req[p] = 1'b0;
    endtask

    // Access with prediction and checking against the bench model.
    task automatic run(input int p, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int idx, cyc, r0, w0, exp_rd, exp_wr;
        logic [TAG_W-1:0] tg;
        logic [DW-1:0] rd, mem_before;
        bit hit, fetch, vwb;
        string wtag, rtag;
        idx = int'(a[OFS_W +: IDX_W]);
        tg = a[AW-1 -: TAG_W];
        hit = mv[p][idx] && (mt[p][idx] == tg);
        fetch = !hit && (!we || is_al(p));
        vwb = fetch && is_wb(p) && mv[p][idx] && md[p][idx];
        exp_rd = fetch ? 1 : 0;
        exp_wr = (vwb ? 1 : 0) + ((we && (!is_wb(p) || (!hit && !is_al(p)))) ? 1 : 0);
        if (vwb) wtag = "R9";
        else if (we && !is_wb(p)) wtag = "R7";
        else if (we && !hit && !is_al(p)) wtag = "R6";
        else if (we) wtag = "R8";
        else wtag = "R10";
        rtag = (we && !hit) ? (is_al(p) ? "R5" : "R6") : "R3";
        r0 = rd_cnt[p];
        w0 = wr_cnt[p];
        mem_before = mem_w[p][a];
        access(p, we, a, d, cyc, rd);
        chk(cyc <= 2000, "R11", "access completed", 64'(cyc), 64'(0));
        chk(rd_cnt[p] - r0 == exp_rd, rtag, "line reads", 64'(rd_cnt[p] - r0), 64'(exp_rd));
        chk(wr_cnt[p] - w0 == exp_wr, wtag, "memory writes", 64'(wr_cnt[p] - w0), 64'(exp_wr));
        if (!we) begin
            chk(rd == sh_w[p][a], hit ? "R2" : "R3", "load data", 64'(rd), 64'(sh_w[p][a]));
            if (hit) chk(cyc == 1, "R2", "load hit cycles", 64'(cyc), 64'(1));
        end else begin
            sh_w[p][a] = d;
            if (!is_wb(p)) begin
                chk(mem_w[p][a] == d, "R7/R12", "memory word after store", 64'(mem_w[p][a]), 64'(d));
            end else if (hit || fetch) begin
                chk(mem_w[p][a] == mem_before, "R8", "memory untouched by store",
                    64'(mem_w[p][a]), 64'(mem_before));
            end else begin
                chk(mem_w[p][a] == d, "R6", "forwarded word", 64'(mem_w[p][a]), 64'(d));
            end
            if (hit && is_wb(p)) chk(cyc == 2, "R4", "store hit cycles", 64'(cyc), 64'(2));
            if (hit && !is_wb(p)) chk(cyc >= 3, "R4", "store hit cycles", 64'(cyc), 64'(3));
        end
        if (fetch) begin
            mv[p][idx] = 1'b1;
            mt[p][idx] = tg;
            md[p][idx] = 1'b0;
        end
        if (we && (hit || fetch) && is_wb(p)) md[p][idx] = 1'b1;
    endtask

    initial begin
        int seed;
        seed = int'($urandom(32'd20_240_611));
        for (int p = 0; p < NP; p++) begin
            cpu_req[p] = 1'b0; cpu_we[p] = 1'b0; cpu_addr[p] = '0; cpu_wdata[p] = '0;
            rd_cnt[p] = 0; wr_cnt[p] = 0; viol[p] = 0; lat_tgt[p] = 1;
            mem_rdata[p] = '0;
            for (int a = 0; a < NWORD; a++) begin
                mem_w[p][a] = init_val(p, a);
                sh_w[p][a] = init_val(p, a);
            end
            for (int l = 0; l < LINES; l++) begin
                mv[p][l] = 1'b0; md[p][l] = 1'b0; mt[p][l] = '0;
            end
        end
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        for (int p = 0; p < NP; p++) begin
            chk(!cpu_ready[p], "R1", "ready after reset", 64'(cpu_ready[p]), 64'(0));
            chk(!mem_req[p], "R1", "mem_req after reset", 64'(mem_req[p]), 64'(0));
        end
        for (int p = 0; p < NP; p++) begin
            run(p, 1'b0, mk(1, 3, 0), '0);            // R1/R3 cold miss
            run(p, 1'b0, mk(1, 3, 2), '0);            // R2 hit in same line
            run(p, 1'b1, mk(1, 3, 1), 32'hDEAD_0001); // R4 store hit
            run(p, 1'b0, mk(1, 3, 1), '0);            // R2 reads new value
            run(p, 1'b0, mk(2, 3, 0), '0);            // R9 dirty eviction (write-back)
            run(p, 1'b0, mk(1, 3, 1), '0);            // R3 refetch returns stored word
            run(p, 1'b0, mk(2, 3, 1), '0);            // R10 clean replacement
            run(p, 1'b1, mk(5, 7, 2), 32'hBEEF_0002); // R5/R6 store miss
            run(p, 1'b0, mk(5, 7, 0), '0);            // R5 neighbour word from memory
            run(p, 1'b0, mk(5, 7, 2), '0);            // R5/R6 stored word visible
            run(p, 1'b1, mk(0, 0, 3), 32'hCAFE_0003); // store miss to a cold line
            run(p, 1'b0, mk(0, 0, 3), '0);
        end
        for (int n = 0; n < 250; n++) begin
            for (int p = 0; p < NP; p++) begin
                run(p, 1'($urandom % 2), mk(int'($urandom % 4), int'($urandom % 4),
                    int'($urandom % 4)), $urandom);
            end
        end
        for (int p = 0; p < NP; p++) begin
            chk(viol[p] == 0, "R11", "ready during pending handshake", 64'(viol[p]), 64'(0));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R11 watchdog actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule